// File: doc/BRIEF.md
# Per-CPU Level Interrupt Aggregator

This block collects `N_WORDS` x 32 level-sensitive interrupt lines and drives one interrupt output per CPU. The lines are first brought into the local clock domain by a two-stage synchronizer. The synchronized levels form a raw status vector that every CPU sees. Each CPU owns a private mask bank. A CPU's output is raised while at least one source is active and left unmasked in that CPU's bank.

Software reaches the block through a plain 32-bit register port. It can read the raw status and its own mask. It changes the mask only through atomic strobes: one address sets mask bits and another clears them, and a 0 bit in either write leaves that mask bit as it was. The same source can therefore be routed to one CPU and held back from another. Nothing is latched. A source stops being pending as soon as its input line falls.

Top module: `lvl_intc`

## Requirements
- R1: Source n appears in status word n/32 at bit n%32. Status word w of any bank is read at byte offset w*4 within that bank.
- R2: A bank holds four groups of N_WORDS words in a fixed order, each register at byte offset (group*N_WORDS + word)*4. Group 0 is raw status, 1 is mask status, 2 is mask-set and 3 is mask-clear. The bank for CPU c starts at byte c*2^BANK_AW, where BANK_AW = clog2(16*N_WORDS). With the default N_WORDS=2 that is c*32. Address bits [1:0] are ignored.
- R3: After reset every mask bit is 1, every CPU output is 0 and the read data is 0.
- R4: A write to a mask-set word sets each mask bit whose data bit is 1. Mask bits whose data bit is 0 are unchanged.
- R5: A write to a mask-clear word clears each mask bit whose data bit is 1. Mask bits whose data bit is 0 are unchanged.
- R6: A source is pending for CPU c when its status bit is 1 and its mask bit in bank c is 0. The mask banks are independent of each other. A mask bit of 1 disables the source.
- R7: Status follows the input level and is never latched. Writes to raw-status or mask-status addresses change nothing.
- R8: Read data appears on the clock after the read request and is 0 in every other cycle. Reads of mask-set and mask-clear addresses return 0.
- R9: A CPU output is registered. It changes one clock after a mask change and three clocks after an input change (two synchronizer stages plus the output register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_src | input | N_WORDS*32 | Level interrupt lines, asynchronous |
| bus_en | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | BANK_AW+CPU_W | Byte address: CPU select above the bank offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the clock after a read |
| cpu_irq | output | N_CPUS | Interrupt output per CPU |

## Verification
A mask write and a change on a synchronized input line can land on the same clock edge. Both feed the same pending term of the output register. The bench drives an input edge and a mask-clear write (and, in a second case, an input fall with a mask-set write) on the same falling edge. It then checks the CPU output at each following falling edge against a cycle count worked out from R9: the mask effect must show one clock in, and the input effect three clocks in. The other CPU's output and mask must stay unaffected throughout.

// File: rtl/lvl_intc_pkg.sv
// Shared definitions for the level interrupt aggregator.
// Assumes: 32-bit register words; the group order below is fixed by the address map.
package lvl_intc_pkg;
    localparam int WORD_BITS = 32;

    // Register group within a CPU bank, in address order.
    typedef enum logic [1:0] {
        GRP_RAW = 2'd0,
        GRP_MSK = 2'd1,
        GRP_SET = 2'd2,
        GRP_CLR = 2'd3
    } grp_e;
endpackage

// File: rtl/lvl_intc_sync.sv
// Two-stage synchronizer for the interrupt lines.
// Assumes: each line is an independent level; skew between lines is acceptable.
module lvl_intc_sync #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    logic [W-1:0] stage1;

    // Shift the asynchronous levels through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            d_out  <= '0;
        end else begin
            stage1 <= d_in;
            d_out  <= stage1;
        end
    end
endmodule

// File: rtl/lvl_intc_regdec.sv
// Address decoder: splits a byte address into CPU bank, register group and word.
// Assumes: the bank window is a power of two; bits [1:0] are ignored.
module lvl_intc_regdec
    import lvl_intc_pkg::*;
#(
    parameter int N_WORDS = 2,
    parameter int N_CPUS  = 2,
    parameter int BANK_AW = 5,
    parameter int CPU_W   = 1,
    parameter int WSEL_W  = 1
) (
    input  logic [BANK_AW+CPU_W-1:0] addr,
    output grp_e                     grp,
    output logic [WSEL_W-1:0]        wsel,
    output logic [CPU_W-1:0]         csel,
    output logic                     hit
);
    localparam int IDX_W = BANK_AW - 2;

    logic [IDX_W-1:0] idx;

    assign idx  = addr[BANK_AW-1:2];
    assign csel = addr[BANK_AW+CPU_W-1:BANK_AW];

    // Divide the word index into group and word, and flag legal addresses.
    always_comb begin
        int unsigned iv;
        int unsigned gv;
        int unsigned wv;
        iv   = int'(idx);
        gv   = iv / N_WORDS;
        wv   = iv % N_WORDS;
        grp  = grp_e'(gv[1:0]);
        wsel = wv[WSEL_W-1:0];
        hit  = (iv < 4 * N_WORDS) && (int'(csel) < N_CPUS);
    end
endmodule

// File: rtl/lvl_intc_bank.sv
// One CPU's mask bank: set/clear strobes, pending reduction and output register.
// Assumes: set_en and clr_en are never high together (one bus port).
module lvl_intc_bank
    import lvl_intc_pkg::*;
#(
    parameter int N_WORDS = 2,
    parameter int WSEL_W  = 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           set_en,
    input  logic                           clr_en,
    input  logic [WSEL_W-1:0]              wsel,
    input  logic [WORD_BITS-1:0]           wdata,
    input  logic [N_WORDS*WORD_BITS-1:0]   status,
    output logic [N_WORDS*WORD_BITS-1:0]   mask,
    output logic                           irq
);
    localparam int N_SRC = N_WORDS * WORD_BITS;

    logic [N_SRC-1:0] pending;

    assign pending = status & ~mask;

    // Apply atomic set or clear to the selected mask word; reset masks all.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '1;
        end else if (set_en) begin
            mask[wsel*WORD_BITS +: WORD_BITS] <= mask[wsel*WORD_BITS +: WORD_BITS] | wdata;
        end else if (clr_en) begin
            mask[wsel*WORD_BITS +: WORD_BITS] <= mask[wsel*WORD_BITS +: WORD_BITS] & ~wdata;
        end
    end

    // Register the OR of all pending sources as the CPU output.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |pending;
    end

    // Checker state: remember last strobe for the set/clear properties.
    logic                 set_q, clr_q;
    logic [WSEL_W-1:0]    wsel_q;
    logic [WORD_BITS-1:0] wdata_q;

    // Capture the previous cycle's strobe, word and data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            set_q   <= 1'b0;
            clr_q   <= 1'b0;
            wsel_q  <= '0;
            wdata_q <= '0;
        end else begin
            set_q   <= set_en;
            clr_q   <= clr_en;
            wsel_q  <= wsel;
            wdata_q <= wdata;
        end
    end

    // R3
    mask_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mask == '1 && !irq));

    // R4
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_q |-> ((mask[wsel_q*WORD_BITS +: WORD_BITS] & wdata_q) == wdata_q));

    // R5
    mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_q |-> ((mask[wsel_q*WORD_BITS +: WORD_BITS] & wdata_q) == '0));

    // R7
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_en && !clr_en) |=> $stable(mask));

    // R6
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pending == '0) |=> !irq);

    // R9
    irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pending != '0) |=> irq);
endmodule

// File: rtl/lvl_intc.sv
// Top of the per-CPU level interrupt aggregator.
// Assumes: one register access per clock; read data is registered.
module lvl_intc
    import lvl_intc_pkg::*;
#(
    parameter int N_WORDS = 2,
    parameter int N_CPUS  = 2,
    parameter int BANK_AW = $clog2(16 * N_WORDS),
    parameter int CPU_W   = (N_CPUS > 1) ? $clog2(N_CPUS) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [N_WORDS*WORD_BITS-1:0]  irq_src,
    input  logic                          bus_en,
    input  logic                          bus_we,
    input  logic [BANK_AW+CPU_W-1:0]      bus_addr,
    input  logic [WORD_BITS-1:0]          bus_wdata,
    output logic [WORD_BITS-1:0]          bus_rdata,
    output logic [N_CPUS-1:0]             cpu_irq
);
    localparam int N_SRC  = N_WORDS * WORD_BITS;
    localparam int WSEL_W = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;

    logic [N_SRC-1:0]     raw_status;
    logic [N_SRC-1:0]     masks [N_CPUS];
    grp_e                 dec_grp;
    logic [WSEL_W-1:0]    dec_wsel;
    logic [CPU_W-1:0]     dec_csel;
    logic                 dec_hit;
    logic [N_CPUS-1:0]    set_en, clr_en;
    logic [WORD_BITS-1:0] sel_mask_word;
    logic                 wr_req, rd_req;

    assign wr_req = bus_en &&  bus_we && dec_hit;
    assign rd_req = bus_en && !bus_we;

    lvl_intc_sync #(.W(N_SRC)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (irq_src),
        .d_out (raw_status)
    );

    lvl_intc_regdec #(
        .N_WORDS (N_WORDS),
        .N_CPUS  (N_CPUS),
        .BANK_AW (BANK_AW),
        .CPU_W   (CPU_W),
        .WSEL_W  (WSEL_W)
    ) u_dec (
        .addr (bus_addr),
        .grp  (dec_grp),
        .wsel (dec_wsel),
        .csel (dec_csel),
        .hit  (dec_hit)
    );

    for (genvar gi = 0; gi < N_CPUS; gi++) begin : g_bank
        // Route set/clear strobes to the addressed bank only.
        assign set_en[gi] = wr_req && (dec_grp == GRP_SET) && (dec_csel == CPU_W'(gi));
        assign clr_en[gi] = wr_req && (dec_grp == GRP_CLR) && (dec_csel == CPU_W'(gi));

        lvl_intc_bank #(
            .N_WORDS (N_WORDS),
            .WSEL_W  (WSEL_W)
        ) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_en (set_en[gi]),
            .clr_en (clr_en[gi]),
            .wsel   (dec_wsel),
            .wdata  (bus_wdata),
            .status (raw_status),
            .mask   (masks[gi]),
            .irq    (cpu_irq[gi])
        );
    end

    // Pick the addressed bank's mask word for reads.
    always_comb begin
        sel_mask_word = '0;
        for (int c = 0; c < N_CPUS; c++) begin
            if (dec_csel == CPU_W'(c)) sel_mask_word = masks[c][dec_wsel*WORD_BITS +: WORD_BITS];
        end
    end

    // Register read data; zero outside a read or on set/clear/unused addresses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (rd_req && dec_hit) begin
            case (dec_grp)
                GRP_RAW: bus_rdata <= raw_status[dec_wsel*WORD_BITS +: WORD_BITS];
                GRP_MSK: bus_rdata <= sel_mask_word;
                default: bus_rdata <= '0;
            endcase
        end else begin
            bus_rdata <= '0;
        end
    end

    // R9
    sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> (raw_status == $past(irq_src, 2)));

    // R8
    rd_strobe_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && (dec_grp == GRP_SET || dec_grp == GRP_CLR)) |=> (bus_rdata == '0));

    // R8
    rd_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> (bus_rdata == '0));

    // R6
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({set_en, clr_en}));
endmodule

// File: tb/lvl_intc_test.sv
// Self-checking bench for lvl_intc with N_WORDS=2, N_CPUS=2 (bank window 32 bytes).
module lvl_intc_test;
    localparam int NW = 2;
    localparam int NC = 2;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [63:0]   irq_src;
    logic          bus_en, bus_we;
    logic [AW-1:0] bus_addr;
    logic [31:0]   bus_wdata;
    logic [31:0]   bus_rdata;
    logic [NC-1:0] cpu_irq;

    int       n_chk  = 0;
    int       n_fail = 0;
    bit       done   = 1'b0;
    bit [63:0] mmask [NC];

    lvl_intc uut (
        .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cpu_irq(cpu_irq)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // R2: byte offset of (cpu, group, word)
    function automatic logic [AW-1:0] adr(input int c, input int g, input int w);
        return AW'(c * 32 + (g * NW + w) * 4);
    endfunction

    function automatic logic [NC-1:0] exp_irq();
        logic [NC-1:0] r;
        for (int c = 0; c < NC; c++) r[c] = |(irq_src & ~mmask[c]);
        return r;
    endfunction

    task automatic bus_wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        bus_en = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        rst_n = 1'b0; irq_src = '0; bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        for (int c = 0; c < NC; c++) mmask[c] = '1;
        repeat (5) @(negedge clk);
        check("R3 irq in reset", 32'(cpu_irq), 32'd0);
        check("R3 rdata in reset", bus_rdata, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int c = 0; c < NC; c++)
            for (int w = 0; w < NW; w++) begin
                bus_rd(adr(c, 1, w), rd);
                check("R3 mask after reset", rd, 32'hFFFF_FFFF);
            end

        // All lines high but everything masked.
        irq_src = '1;
        settle();
        check("R3 masked output", 32'(cpu_irq), 32'd0);
        bus_rd(adr(1, 0, 1), rd);
        check("R1 status all ones", rd, 32'hFFFF_FFFF);

        // R1/R6 sweep: one source, unmasked on one CPU only.
        for (int n = 0; n < 64; n++) begin
            int c = n % 2;
            irq_src = 64'd1 << n;
            bus_wr(adr(c, 3, n / 32), 32'd1 << (n % 32));
            mmask[c][n] = 1'b0;
            settle();
            check("R6 single source routing", 32'(cpu_irq), 32'(exp_irq()));
            bus_rd(adr(1 - c, 0, n / 32), rd);
            check("R1 status bit position", rd, 32'd1 << (n % 32));
            bus_rd(adr(c, 1, n / 32), rd);
            check("R2 mask status word", rd, ~(32'd1 << (n % 32)));
            bus_rd(adr(1 - c, 1, n / 32), rd);
            check("R6 other bank untouched", rd, 32'hFFFF_FFFF);
            bus_wr(adr(c, 2, n / 32), 32'd1 << (n % 32));
            mmask[c][n] = 1'b1;
        end

        // R5 and R4 with patterns.
        bus_wr(adr(0, 3, 1), 32'hA5A5_0F0F);
        bus_rd(adr(0, 1, 1), rd);
        check("R5 clear pattern", rd, ~32'hA5A5_0F0F);
        bus_wr(adr(0, 2, 1), 32'h0000_0F00);
        bus_rd(adr(0, 1, 1), rd);
        check("R4 set pattern", rd, ~32'hA5A5_0F0F | 32'h0000_0F00);
        bus_rd(adr(0, 1, 0), rd);
        check("R4 other word unchanged", rd, 32'hFFFF_FFFF);
        mmask[0][63:32] = {~32'hA5A5_0F0F | 32'h0000_0F00};

        // R7 read-only groups.
        bus_wr(adr(0, 1, 1), 32'h0000_0000);
        bus_wr(adr(0, 0, 1), 32'hFFFF_FFFF);
        bus_rd(adr(0, 1, 1), rd);
        check("R7 mask status write ignored", rd, ~32'hA5A5_0F0F | 32'h0000_0F00);
        irq_src = '0;
        settle();
        bus_rd(adr(0, 0, 1), rd);
        check("R7 status write ignored", rd, 32'd0);

        // R8 strobe addresses read zero, and idle read data is zero.
        bus_rd(adr(0, 2, 1), rd);
        check("R8 set address reads zero", rd, 32'd0);
        bus_rd(adr(1, 3, 0), rd);
        check("R8 clear address reads zero", rd, 32'd0);
        irq_src = 64'd1 << 32;
        settle();
        bus_rd(adr(0, 0, 1), rd);
        check("R8 read data", rd, 32'd1);
        @(negedge clk);
        check("R8 idle data zero", bus_rdata, 32'd0);

        // R7 level follows input, no latching.
        check("R7 output on level", 32'(cpu_irq), 32'(exp_irq()));
        irq_src = '0;
        settle();
        check("R7 output drops with level", 32'(cpu_irq), 32'd0);

        // R9 input latency: three clocks.
        irq_src = 64'd1;
        bus_wr(adr(1, 3, 0), 32'd0);
        settle();
        bus_wr(adr(0, 3, 0), 32'd1);
        mmask[0][0] = 1'b0;
        check("R9 mask effect one clock later (before)", 32'(cpu_irq), 32'd0);
        @(negedge clk);
        check("R9 mask effect one clock later", 32'(cpu_irq), 32'd1);
        irq_src = '0;
        settle();
        @(negedge clk);
        irq_src = 64'd1;
        @(negedge clk);
        check("R9 input edge +1", 32'(cpu_irq), 32'd0);
        @(negedge clk);
        check("R9 input edge +2", 32'(cpu_irq), 32'd0);
        @(negedge clk);
        check("R9 input edge +3", 32'(cpu_irq), 32'd1);

        // Same-edge: source rise and mask-clear on CPU1 together.
        irq_src = '0;
        settle();
        @(negedge clk);
        irq_src = 64'd1 << 5;
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = adr(1, 3, 0); bus_wdata = 32'd1 << 5;
        mmask[1][5] = 1'b0;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
        check("R9 coincident +1", 32'(cpu_irq), 32'd0);
        @(negedge clk);
        check("R9 coincident +2", 32'(cpu_irq), 32'd0);
        @(negedge clk);
        check("R6 coincident +3 CPU1 only", 32'(cpu_irq), 32'b10);

        // Same-edge: source fall and mask-set on CPU1 together.
        irq_src = '0;
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = adr(1, 2, 0); bus_wdata = 32'd1 << 5;
        mmask[1][5] = 1'b1;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
        @(negedge clk);
        check("R4 masked one clock after set", 32'(cpu_irq), 32'd0);
        settle();
        check("R6 final outputs", 32'(cpu_irq), 32'(exp_irq()));
        bus_rd(adr(0, 1, 0), rd);
        check("R6 CPU0 mask word0", rd, mmask[0][31:0]);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule